// File: doc/BRIEF.md
# Bus Slave Transfer Response Unit

This block is the response half of a pipelined system-bus slave. When the slave is selected and the bus is ready, it captures the address phase of an active transfer. It then runs the data phase to one of five endings: an immediate OKAY, an OKAY preceded by wait cycles, a SPLIT, a RETRY or an ERROR.

The slave's local logic picks the outcome of each transfer through a small control port: go now, stall for a given number of cycles, busy (cannot complete), or fault. A busy outcome becomes SPLIT when the instance is built as split-capable and holds no split. In every other case it becomes RETRY. For a split, the unit records which master was turned away. When the local logic later signals resume, the unit pulses that master's bit on a per-master release vector for one cycle and clears the record.

After an ERROR, the remaining sequential beats of the failed burst are left alone until a new non-sequential transfer starts. The register file and the address decode sit outside this unit.

Top module: `bus_slave_resp`

## Requirements
- R1: After reset, ready_o is 1, resp_o is OKAY (00), wr_en_o is 0 and unsplit_o is all zero.
- R2: A taken transfer with outcome go (00), or stall (01) with a wait request of 0, shows ready_o=1 and resp_o=OKAY in the next cycle. In that same cycle wr_en_o equals the captured write_i.
- R3: A taken transfer with outcome stall (01) and wait request N (1..16) holds ready_o low with resp_o=OKAY for exactly N cycles. It then shows ready_o=1 with OKAY, and wr_en_o equals the captured write_i only in that final cycle.
- R4: A wait request above 16 is treated as 16, so ready_o is never low for more than 16 cycles in a row.
- R5: Outcome fault (11) produces ERROR (01) over two cycles: ready_o=0 in the first cycle and ready_o=1 in the second, with the same code in both. No write is issued.
- R6: Outcome busy (10) on a split-capable instance holding no split produces a two-cycle SPLIT (11) response. The unit also records master_i from the address phase.
- R7: Outcome busy produces a two-cycle RETRY (10) when a split is already held, or when the instance is built without split capability. In that case no new master is recorded.
- R8: resume_i while a split is held sets only bit master_id of unsplit_o for exactly one cycle and clears the record. A later busy outcome then gets SPLIT again.
- R9: resume_i while no split is held leaves unsplit_o at zero.
- R10: Address phases that are not selected, or that carry trans_i IDLE (00) or BUSY (01), are not taken. They leave ready_o=1, resp_o=OKAY and wr_en_o=0.
- R11: After an ERROR, SEQ (11) transfers are ignored as in R10 until a NONSEQ (10) transfer is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Slave selected in the address phase |
| trans_i | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| write_i | input | 1 | Address phase direction, 1 = write |
| master_i | input | $clog2(MASTERS) | Number of the master owning the address phase |
| ready_i | input | 1 | Bus-level ready; the address phase is taken only when high |
| outcome_i | input | 2 | Local decision: 00 go, 01 stall, 10 busy, 11 fault |
| wait_req_i | input | WAIT_W | Requested wait cycles for a stall |
| resume_i | input | 1 | Local logic can now serve the split master |
| ready_o | output | 1 | Data phase ready |
| resp_o | output | 2 | Response: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| wr_en_o | output | 1 | One-cycle write strobe at a successful write completion |
| unsplit_o | output | MASTERS | Per-master release pulse for the split master |

## Verification
Two situations are hard to reach from the ports. The first is a busy outcome arriving while a split is still held, which only appears if resume is withheld across several transfers. The second is a sequential beat that follows an ERROR before any new burst has begun. Random stimulus issues resume only rarely and mixes SEQ beats freely after faults, so both cases come up many times. Directed sequences also pin them down in a fixed order: split, busy again, release, release again, split again.

// File: rtl/bus_slave_resp.sv
module bus_slave_resp #(
  parameter int MASTERS       = 8,
  parameter int MAX_WAIT      = 16,
  parameter int WAIT_W        = 5,
  parameter bit SPLIT_CAPABLE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_i,
  input  logic [1:0]                 trans_i,
  input  logic                       write_i,
  input  logic [$clog2(MASTERS)-1:0] master_i,
  input  logic                       ready_i,
  input  logic [1:0]                 outcome_i,
  input  logic [WAIT_W-1:0]          wait_req_i,
  input  logic                       resume_i,
  output logic                       ready_o,
  output logic [1:0]                 resp_o,
  output logic                       wr_en_o,
  output logic [MASTERS-1:0]         unsplit_o
);
  localparam int IDW = $clog2(MASTERS);
  localparam int CW  = $clog2(MAX_WAIT + 1);
  localparam logic [1:0] OKAY = 2'b00, ERR = 2'b01, RETRY = 2'b10, SPLIT = 2'b11;

  typedef enum logic [1:0] {PH_FREE, PH_WAIT, PH_FIRST, PH_SECOND} ph_t;

  ph_t            ph;
  logic [1:0]     code;
  logic [CW-1:0]  cnt;
  logic           wr_q;
  logic           held;
  logic [IDW-1:0] held_id;
  logic           drop;
  logic [CW-1:0]  wclip;
  logic           take;

  assign ready_o = !(ph == PH_WAIT || ph == PH_FIRST);
  assign resp_o  = code;
  assign wclip   = (32'(wait_req_i) > MAX_WAIT) ? CW'(MAX_WAIT) : CW'(wait_req_i);
  assign take    = sel_i && ready_i && ready_o && trans_i[1] && !(drop && trans_i == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_FREE;
      code      <= OKAY;
      cnt       <= '0;
      wr_q      <= 1'b0;
      held      <= 1'b0;
      held_id   <= '0;
      drop      <= 1'b0;
      wr_en_o   <= 1'b0;
      unsplit_o <= '0;
    end else begin
      wr_en_o   <= 1'b0;
      unsplit_o <= '0;
      if (held && resume_i) begin
        unsplit_o <= MASTERS'(1) << held_id;
        held      <= 1'b0;
      end
      case (ph)
        PH_WAIT: begin
          if (cnt <= CW'(1)) begin
            ph      <= PH_FREE;
            wr_en_o <= wr_q;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_FIRST: ph <= PH_SECOND;
        default: begin
          ph   <= PH_FREE;
          code <= OKAY;
        end
      endcase
      if (take) begin
        if (trans_i == 2'b10) drop <= 1'b0;
        wr_q <= write_i;
        case (outcome_i)
          2'b00: begin
            ph      <= PH_FREE;
            code    <= OKAY;
            wr_en_o <= write_i;
          end
          2'b01: begin
            code <= OKAY;
            if (wclip == '0) begin
              ph      <= PH_FREE;
              wr_en_o <= write_i;
            end else begin
              ph  <= PH_WAIT;
              cnt <= wclip;
            end
          end
          2'b10: begin
            ph <= PH_FIRST;
            if (SPLIT_CAPABLE && !held) begin
              code    <= SPLIT;
              held    <= 1'b1;
              held_id <= master_i;
            end else begin
              code <= RETRY;
            end
          end
          default: begin
            ph   <= PH_FIRST;
            code <= ERR;
            drop <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bus_slave_resp_chk.sv
module bus_slave_resp_chk #(
  parameter int MASTERS  = 8,
  parameter int MAX_WAIT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready_o,
  input logic [1:0]         resp_o,
  input logic               wr_en_o,
  input logic [MASTERS-1:0] unsplit_o
);
  logic [$clog2(MAX_WAIT + 2):0] lowrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowrun <= '0;
    else if (ready_o) lowrun <= '0;
    else if (32'(lowrun) <= MAX_WAIT) lowrun <= lowrun + 1'b1;
  end

  assert_two_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && resp_o != 2'b00) |=> (ready_o && resp_o == $past(resp_o)));

  assert_release_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unsplit_o));

  assert_release_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (unsplit_o != '0) |=> (unsplit_o == '0));

  assert_write_on_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (ready_o && resp_o == 2'b00));

  assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(lowrun) <= MAX_WAIT);
endmodule

bind bus_slave_resp bus_slave_resp_chk #(.MASTERS(MASTERS), .MAX_WAIT(MAX_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_o(ready_o), .resp_o(resp_o),
  .wr_en_o(wr_en_o), .unsplit_o(unsplit_o)
);

// File: tb/test_bus_slave_resp.sv
module test_bus_slave_resp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic [1:0] tr = 2'b00;
  logic       wr = 1'b0;
  logic [2:0] mid = 3'd0;
  logic [1:0] oc = 2'b00;
  logic [4:0] wreq = 5'd0;
  logic       resume = 1'b0;
  logic       rdy, wen, rdy2, wen2;
  logic [1:0] resp, resp2;
  logic [7:0] usp, usp2;
  int checks = 0, errors = 0;
  bit held = 0, drop = 0;
  int held_id = 0;

  always #10 clk = ~clk;

  bus_slave_resp i_bus_slave_resp (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .trans_i(tr), .write_i(wr), .master_i(mid),
    .ready_i(rdy), .outcome_i(oc), .wait_req_i(wreq), .resume_i(resume),
    .ready_o(rdy), .resp_o(resp), .wr_en_o(wen), .unsplit_o(usp));

  bus_slave_resp #(.SPLIT_CAPABLE(1'b0)) i_nosplit (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .trans_i(tr), .write_i(wr), .master_i(mid),
    .ready_i(rdy2), .outcome_i(oc), .wait_req_i(wreq), .resume_i(resume),
    .ready_o(rdy2), .resp_o(resp2), .wr_en_o(wen2), .unsplit_o(usp2));

  task automatic chk(string tag, logic [10:0] got, logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xfer(bit s, logic [1:0] t, bit w, logic [1:0] o, int wc, int id);
    bit act; int n; logic [1:0] code; string tag; bit is_split;
    @(negedge clk);
    sel = s; tr = t; wr = w; oc = o; wreq = 5'(wc); mid = 3'(id);
    act = s && t[1] && !(drop && t == 2'b11);
    tag = (drop && s && t == 2'b11) ? "R11" : "R10";
    if (act && t == 2'b10) drop = 0;
    is_split = 0; code = 2'b00; n = 1;
    if (act) begin
      case (o)
        2'b00: tag = "R2";
        2'b01: begin n = ((wc > 16) ? 16 : wc) + 1; tag = (wc > 16) ? "R4" : (wc == 0) ? "R2" : "R3"; end
        2'b10: begin
          n = 2;
          if (!held) begin code = 2'b11; held = 1; held_id = id; is_split = 1; tag = "R6"; end
          else begin code = 2'b10; tag = "R7"; end
        end
        default: begin n = 2; code = 2'b01; drop = 1; tag = "R5"; end
      endcase
    end
    @(negedge clk);
    sel = 0; tr = 2'b00;
    for (int k = 1; k <= n; k++) begin
      if (k > 1) @(negedge clk);
      if (!act) chk(tag, {rdy, resp, wen, 7'd0}, {1'b1, 2'b00, 1'b0, 7'd0});
      else if (o[1]) chk(tag, {rdy, resp, wen, 7'd0}, {(k == 2), code, 1'b0, 7'd0});
      else chk(tag, {rdy, resp, wen, 7'd0}, {(k == n), 2'b00, (k == n) && w, 7'd0});
      if (act && o == 2'b10 && k == 1) chk("R7", {resp2, usp2, 1'b0}, {2'b10, 8'd0, 1'b0});
    end
    if (is_split) chk("R6", {3'd0, usp}, 11'd0);
  endtask

  task automatic release_split();
    logic [7:0] exp;
    @(negedge clk);
    resume = 1;
    exp = held ? (8'd1 << held_id) : 8'd0;
    @(negedge clk);
    resume = 0;
    chk(held ? "R8" : "R9", {3'd0, usp}, {3'd0, exp});
    held = 0;
    @(negedge clk);
    chk("R8", {3'd0, usp}, 11'd0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", {rdy, resp, wen, usp}, {1'b1, 2'b00, 1'b0, 8'd0});
    rst_n = 1;
    @(negedge clk);
    chk("R1", {rdy, resp, wen, usp}, {1'b1, 2'b00, 1'b0, 8'd0});
    xfer(1, 2'b10, 1, 2'b00, 0, 0);
    xfer(1, 2'b10, 1, 2'b01, 0, 1);
    xfer(1, 2'b10, 1, 2'b01, 3, 1);
    xfer(1, 2'b10, 0, 2'b01, 16, 2);
    xfer(1, 2'b10, 1, 2'b01, 25, 2);
    xfer(0, 2'b10, 1, 2'b00, 0, 0);
    xfer(1, 2'b00, 1, 2'b00, 0, 0);
    xfer(1, 2'b01, 1, 2'b00, 0, 0);
    xfer(1, 2'b10, 0, 2'b10, 0, 5);
    xfer(1, 2'b10, 0, 2'b10, 0, 2);
    release_split();
    release_split();
    xfer(1, 2'b10, 1, 2'b10, 0, 3);
    release_split();
    xfer(1, 2'b10, 1, 2'b11, 0, 4);
    xfer(1, 2'b11, 1, 2'b00, 0, 4);
    xfer(1, 2'b11, 1, 2'b01, 5, 4);
    xfer(1, 2'b10, 1, 2'b00, 0, 4);
    xfer(1, 2'b11, 1, 2'b00, 0, 4);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(9) == 0) release_split();
      else xfer($urandom_range(5) != 0, 2'($urandom_range(3)), 1'($urandom_range(1)),
                2'($urandom_range(3)), $urandom_range(20), $urandom_range(7));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule